// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the target side of a two-wire serial bus (I2C-style) placed in front of a byte-addressed on-chip RAM. It oversamples SCL and SDA on the system clock and recognises start and stop conditions. It shifts in a device byte and answers only when the type code and the two strap-selected bits match. After a write-mode device byte it collects a two-byte word address and then stores data bytes. After a read-mode device byte it returns bytes from the current address pointer.

The top bit of the high address byte steers an access either to the RAM array or to a single 8-bit control register. Array addresses are split into a page number and a 6-bit offset within a page. Writes roll over inside the page, while reads advance through the whole address space. The block only pulls SDA low (an open-drain enable). The board or bench forms the wired-AND line.

Top module: `tws_slave`

## Requirements
- R1: A falling SDA while SCL is high (start) always begins reception of a device byte, even in the middle of a transfer. A rising SDA while SCL is high (stop) always returns the block to standby. A stop that comes before both address bytes have been received leaves the address pointer unchanged.
- R2: The device byte is received MSB first. The block acknowledges it only when bits 7..4 are 1010, bit 3 is 0, and bits 2..1 equal `sel_pins[1:0]`. To acknowledge, it holds SDA low through the ninth SCL high phase and releases SDA after the ninth falling edge.
- R3: When the device byte does not match, no acknowledge is given. The block then ignores every byte until the next start, and the memory contents stay unchanged.
- R4: With bit 0 of the device byte at 0 (write), the next two bytes are the word address, high byte first, and each one is acknowledged.
- R5: Each write data byte is acknowledged and stored at the pointer. The low 6 bits of the pointer then step by one and wrap from 63 to 0, while the page bits stay as they are.
- R6: Bit 7 of the high address byte selects the target: 0 selects the array and 1 selects the control register. Control-register writes and reads do not touch the array and do not move the pointer.
- R7: With bit 0 of the device byte at 1 (read), the block drives the byte at the pointer MSB first. SDA changes only while SCL is low.
- R8: In a read, a master ACK (SDA low on the ninth clock) starts the next byte from the next address, including across page boundaries. A NACK makes the block release SDA and go to standby.
- R9: Every array byte read moves the pointer one past that byte. A read that comes with no word address continues from this pointer.
- R10: The address is 15 bits. A14..A8 come from bits 6..0 of the high byte and A7..A0 from the low byte, so the page is A14..A6 and the offset is A5..A0.
- R11: SDA is released during and after reset, in standby, and whenever the master is sending data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sel_pins | input | 2 | Strapped device select levels |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The hardest case to reach is the boundary between a write that wraps inside a page and a read that crosses into the next page. Both depend on the pointer state left by earlier transfers, and that state is visible only through later reads. The stimulus therefore prepares the bytes on both sides of a page edge and then writes across the page end. It checks that the wrapped byte landed at the start of the same page and that the next page kept its value. Finally it reads sequentially across the edge and issues a current-address read right after a NACK-terminated read.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT
  } tws_state_t;

  localparam logic [3:0] TYPE_CODE = 4'b1010;
  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tws_mem.sv
module tws_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6,
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        sel_pins,
  output logic              sda_oe,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [MEM_AW-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata
);
  localparam int HI_W = ADDR_W - BYTE_BITS;

  tws_state_t       state;
  logic [3:0]       bcnt;
  logic [7:0]       shreg, txreg, ahi, ctl_reg, rd_byte;
  logic             ack_ph, mack, rd_req, ctl_sel, dev_match;
  logic [ADDR_W-1:0] addr;

  assign rd_byte   = ctl_sel ? ctl_reg : mem_rdata;
  assign mem_raddr = addr[MEM_AW-1:0];
  assign dev_match = (shreg[7:4] == TYPE_CODE) && !shreg[3] && (shreg[2:1] == sel_pins);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; bcnt <= '0; shreg <= '0; txreg <= '0; ahi <= '0;
      ctl_reg <= '0; ack_ph <= 1'b0; mack <= 1'b0; rd_req <= 1'b0;
      ctl_sel <= 1'b0; addr <= '0; sda_oe <= 1'b0;
      mem_we <= 1'b0; mem_waddr <= '0; mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start_det) begin
        state <= ST_DEV; bcnt <= '0; ack_ph <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE; bcnt <= '0; ack_ph <= 1'b0; sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: ;
          ST_RDAT: begin
            if (scl_rise) begin
              bcnt <= bcnt + 4'd1;
              if (bcnt == 4'd8) begin
                mack <= ~sda_s;
                if (!ctl_sel) addr <= addr + 1'b1;
              end
            end else if (scl_fall) begin
              if (bcnt == 4'd8) begin
                sda_oe <= 1'b0;
              end else if (bcnt == 4'd9) begin
                bcnt <= '0;
                if (mack) begin
                  txreg  <= rd_byte;
                  sda_oe <= ~rd_byte[7];
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                txreg  <= {txreg[6:0], 1'b0};
                sda_oe <= ~txreg[6];
              end
            end
          end
          default: begin
            if (scl_rise && !ack_ph && bcnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              bcnt  <= bcnt + 4'd1;
            end else if (scl_fall && !ack_ph && bcnt == 4'd8) begin
              ack_ph <= 1'b1;
              sda_oe <= 1'b1;
              case (state)
                ST_DEV: begin
                  rd_req <= shreg[0];
                  if (!dev_match) begin
                    state  <= ST_IDLE;
                    ack_ph <= 1'b0;
                    sda_oe <= 1'b0;
                    bcnt   <= '0;
                  end
                end
                ST_AHI: ahi <= shreg;
                ST_ALO: begin
                  addr    <= {ahi[HI_W-1:0], shreg};
                  ctl_sel <= ahi[7];
                end
                ST_WDAT: begin
                  if (ctl_sel) ctl_reg <= shreg;
                  else begin
                    mem_we    <= 1'b1;
                    mem_waddr <= addr[MEM_AW-1:0];
                    mem_wdata <= shreg;
                  end
                end
                default: ;
              endcase
            end else if (scl_fall && ack_ph) begin
              ack_ph <= 1'b0;
              bcnt   <= '0;
              sda_oe <= 1'b0;
              case (state)
                ST_DEV: begin
                  if (rd_req) begin
                    state  <= ST_RDAT;
                    txreg  <= rd_byte;
                    sda_oe <= ~rd_byte[7];
                  end else begin
                    state <= ST_AHI;
                  end
                end
                ST_AHI: state <= ST_ALO;
                ST_ALO: state <= ST_WDAT;
                ST_WDAT: if (!ctl_sel) addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
                default: ;
              endcase
            end
          end
        endcase
      end
    end
  end

  // SDA only ever moves while SCL is low (R7)
  assert_sda_moves_low_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  // standby never holds the line (R11)
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);

  // a control-register access never writes the array (R6)
  assert_ctl_no_array_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !ctl_sel);

  // outside reads, the line is pulled only in an acknowledge slot (R2)
  assert_ack_slot_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && state != ST_RDAT) |-> ack_ph);

  // one array write per data byte (R5)
  assert_we_single_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
endmodule

// File: rtl/tws_slave.sv
module tws_slave #(
  parameter int ADDR_W      = 15,
  parameter int PAGE_W      = 6,
  parameter int MEM_AW      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] sel_pins,
  output logic       sda_oe
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_waddr, mem_raddr;
  logic [7:0]        mem_wdata, mem_rdata;

  tws_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tws_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .MEM_AW(MEM_AW)) u_ctrl (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sel_pins(sel_pins),
    .sda_oe(sda_oe), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
  );

  tws_mem #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: tb/sim_tws_slave.sv
`timescale 1ns/1ps
module sim_tws_slave;
  localparam int HALF = 20;
  localparam logic [1:0] SEL = 2'b10;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [1:0] sel_pins = SEL;
  int checks = 0, errs = 0;
  bit want_rel = 1'b1;
  bit done = 1'b0;

  int exp_mem [0:2047];
  int exp_ptr = 0;
  int exp_ctl = 0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  tws_slave u0 (.clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
                .sel_pins(sel_pins), .sda_oe(sda_oe));

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model's line-release expectation (R11)
  always @(negedge clk) begin
    if (!rst && !done && want_rel) begin
      checks++;
      if (sda_oe) begin
        errs++;
        $display("FAIL R11 clock-compare actual sda_oe=1 expected=0 at %0t", $time);
      end
    end
  end

  task automatic bus_start();
    want_rel = 1'b1;
    sda_m = 1'b1; wclk(HALF);
    scl_m = 1'b1; wclk(HALF);
    sda_m = 1'b0; wclk(HALF);
    scl_m = 1'b0; wclk(4);
  endtask

  task automatic bus_stop();
    want_rel = 1'b1;
    sda_m = 1'b0; wclk(HALF);
    scl_m = 1'b1; wclk(HALF);
    sda_m = 1'b1; wclk(HALF);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    want_rel = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(HALF);
      scl_m = 1'b1; wclk(HALF);
      if (i == 0) want_rel = 1'b0;
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wclk(HALF);
    scl_m = 1'b1; wclk(HALF/2);
    ack = !sda_line; wclk(HALF/2);
    scl_m = 1'b0; wclk(4);
  endtask

  task automatic get_byte(input bit ack, output logic [7:0] b);
    want_rel = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wclk(HALF);
      scl_m = 1'b1; wclk(HALF/2);
      b[i] = sda_line; wclk(HALF/2);
      scl_m = 1'b0;
    end
    wclk(4);
    want_rel = 1'b1;
    sda_m = !ack; wclk(HALF-4);
    scl_m = 1'b1; wclk(HALF);
    want_rel = !ack;
    scl_m = 1'b0; wclk(1);
    sda_m = 1'b1; wclk(3);
  endtask

  function automatic logic [7:0] dev(input logic [1:0] s, input bit rw);
    return {4'b1010, 1'b0, s, rw};
  endfunction

  task automatic send_addr(input bit flag, input logic [14:0] a, input string tag);
    bit ack;
    put_byte({flag, a[14:8]}, ack); chk(ack, {tag, " R4 hi ack"}, ack, 1);
    put_byte(a[7:0], ack);          chk(ack, {tag, " R4 lo ack"}, ack, 1);
  endtask

  task automatic wr_seq(input bit flag, input logic [14:0] a, input int n,
                        input logic [7:0] first, input string tag);
    bit ack;
    int ptr = int'(a);
    bus_start();
    put_byte(dev(SEL, 1'b0), ack); chk(ack, {tag, " R2 dev ack"}, ack, 1);
    send_addr(flag, a, tag);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = first + 8'(k * 17);
      put_byte(d, ack); chk(ack, {tag, " R5 data ack"}, ack, 1);
      if (flag) exp_ctl = int'(d);
      else begin
        exp_mem[ptr % 2048] = int'(d);
        ptr = (ptr & ~63) | ((ptr + 1) & 63);
      end
    end
    bus_stop();
    exp_ptr = ptr;
  endtask

  task automatic rd_body(input bit flag, input int n, input string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      int e = flag ? exp_ctl : exp_mem[exp_ptr % 2048];
      get_byte(k != n-1, b);
      chk(int'(b) == e, {tag, " R7 R8 read data"}, b, e);
      if (!flag) exp_ptr = (exp_ptr + 1) & 32'h7fff;
    end
    bus_stop();
  endtask

  task automatic rd_rand(input bit flag, input logic [14:0] a, input int n, input string tag);
    bit ack;
    bus_start();
    put_byte(dev(SEL, 1'b0), ack); chk(ack, {tag, " R2 dev ack"}, ack, 1);
    send_addr(flag, a, tag);
    bus_start(); // repeated start, R1
    put_byte(dev(SEL, 1'b1), ack); chk(ack, {tag, " R1 restart dev ack"}, ack, 1);
    exp_ptr = int'(a);
    rd_body(flag, n, tag);
  endtask

  task automatic rd_cur(input int n, input string tag);
    bit ack;
    bus_start();
    put_byte(dev(SEL, 1'b1), ack); chk(ack, {tag, " R9 dev ack"}, ack, 1);
    rd_body(1'b0, n, tag);
  endtask

  initial begin
    bit ack;
    for (int i = 0; i < 2048; i++) exp_mem[i] = -1;
    wclk(5);
    chk(sda_oe == 1'b0, "R11 reset release", sda_oe, 0);
    rst = 1'b0;
    wclk(5);
    chk(sda_oe == 1'b0, "R11 idle after reset", sda_oe, 0);

    // basic write and random read, address split per R10
    wr_seq(1'b0, 15'h0100, 4, 8'h3C, "w100");
    rd_rand(1'b0, 15'h0100, 4, "r100 R10");

    // current-address read after a NACK-ended read (R9)
    rd_rand(1'b0, 15'h0100, 1, "r100one");
    rd_cur(2, "cur R9");

    // prepare around the page 4/5 edge, then cross it sequentially (R8)
    wr_seq(1'b0, 15'h013E, 2, 8'hA1, "w13e");
    wr_seq(1'b0, 15'h0140, 2, 8'h52, "w140");
    wr_seq(1'b0, 15'h0180, 1, 8'h77, "w180");
    // in-page wrap: 0x17E,0x17F then 0x140 (R5)
    wr_seq(1'b0, 15'h017E, 3, 8'hC4, "wrap R5");
    rd_rand(1'b0, 15'h0180, 1, "next page untouched R5");
    rd_rand(1'b0, 15'h0140, 1, "wrapped byte R5");
    rd_rand(1'b0, 15'h013E, 4, "cross page R8");
    // after NACK the line stays released until stop (checked per clock, R8)
    chk(sda_line == 1'b1, "R8 line free after NACK", sda_line, 1);

    // wrong select bits: no ack, nothing written (R3)
    bus_start();
    put_byte(dev(2'b01, 1'b0), ack); chk(!ack, "R3 select mismatch nack", ack, 0);
    put_byte(8'h01, ack); chk(!ack, "R3 ignored byte", ack, 0);
    put_byte(8'h00, ack); chk(!ack, "R3 ignored byte", ack, 0);
    put_byte(8'hEE, ack); chk(!ack, "R3 ignored byte", ack, 0);
    bus_stop();
    rd_rand(1'b0, 15'h0100, 1, "R3 memory unchanged");

    // wrong type code (R2)
    bus_start();
    put_byte({4'b1011, 1'b0, SEL, 1'b0}, ack); chk(!ack, "R2 type mismatch nack", ack, 0);
    bus_stop();
    bus_start();
    put_byte({4'b1010, 1'b1, SEL, 1'b0}, ack); chk(!ack, "R2 bit3 set nack", ack, 0);
    bus_stop();

    // control register (R6)
    wr_seq(1'b1, 15'h0101, 1, 8'h5A, "ctl write R6");
    rd_rand(1'b1, 15'h0101, 2, "ctl read R6");
    rd_rand(1'b0, 15'h0101, 1, "array untouched R6");

    // stop before the low address byte: pointer kept (R1)
    bus_start();
    put_byte(dev(SEL, 1'b0), ack); chk(ack, "R1 dev ack", ack, 1);
    put_byte(8'h07, ack); chk(ack, "R1 hi ack", ack, 1);
    bus_stop();
    rd_cur(1, "R1 pointer kept");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1'b1;
    errs++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule